// File: doc/BRIEF.md
# NAND Sector Hamming ECC Engine

This block protects one NAND sector with a single-error-correcting Hamming code. As the sector's bytes stream through it, one byte per clock, the generator accumulates a pair of parities for every bit of a data bit's address. One parity in each pair covers the data bits whose address bit is one. The other covers the data bits whose address bit is zero. When software or a controller reads the result, the block packs the pairs into a code word and inverts it. That read also clears the accumulator for the next sector.

The checker is an independent one-cycle pipeline. It takes a code that was stored alongside the sector and a code that was calculated when the sector was read back. It XORs the two and classifies the difference. A clean match reports no error. A difference whose two halves are exact complements gives the byte and bit to flip. A difference with a single set bit marks damage inside the stored code only. Anything else is uncorrectable. The block only reports the location; the data itself is repaired by whoever owns the buffer.

Top module: `nand_hecc_engine`

## Requirements
- R1: While reset is high, the next clock edge leaves gen_done, code_valid and res_valid low.
- R2: Let the address of a data bit be {byte index, bit position}, so its width is HALF_W. For each address bit k, the upper half bit k is the parity of all data bits whose address bit k is 1. The lower half bit k is the parity of those whose address bit k is 0. code_out is the bitwise inverse of {upper, lower}, and bits 7:0 form the first byte of the code.
- R3: A sector of all 0xFF bytes yields a code with every bit set.
- R4: gen_done rises in the cycle after the SECTOR_BYTES-th accepted byte. Bytes offered while gen_done is high leave the accumulated code unchanged.
- R5: A code_rd pulse makes code_valid high in the next cycle, with code_out holding the code of the bytes accepted before that cycle. The same edge clears the accumulator and gen_done. A byte offered in the same cycle as code_rd becomes byte 0 of the new sector.
- R6: When the stored code equals the calculated code, res_kind is 0 (clean).
- R7: When the upper half of diff = stored ^ calc, XORed with its lower half, is all ones, res_kind is 1 (fixed). err_bit is diff[HALF_W+2:HALF_W] and err_byte is diff[CODE_W-1:HALF_W+3].
- R8: A difference that passes the R7 complement test but names a byte index of SECTOR_BYTES or more gives res_kind 3 (uncorrectable).
- R9: A difference with exactly one set bit gives res_kind 2 (code bit damaged; data intact).
- R10: Any other nonzero difference, including two flipped data bits, gives res_kind 3.
- R11: res_valid is high in exactly the cycle after each chk_valid cycle, and the result belongs to the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Sector byte strobe |
| byte_data | input | 8 | Sector byte |
| code_rd | input | 1 | Read the code and restart accumulation |
| gen_done | output | 1 | Full sector accumulated |
| code_valid | output | 1 | code_out updated this cycle |
| code_out | output | CODE_W | Inverted packed code, byte 0 in bits 7:0 |
| chk_valid | input | 1 | Compare request |
| chk_stored | input | CODE_W | Code read from the spare area |
| chk_calc | input | CODE_W | Code calculated over the read data |
| res_valid | output | 1 | Classification valid |
| res_kind | output | 2 | 0 clean, 1 fixed, 2 code bit, 3 uncorrectable |
| err_byte | output | BYTE_W | Byte index to correct (kind 1) |
| err_bit | output | 3 | Bit within that byte (kind 1) |

## Verification
The read-and-restart action and byte acceptance can happen in the same clock cycle. The bench provokes this by asserting code_rd together with the first byte of the next sector. It then judges two things: the code returned must match the model of the previous sector without that byte, and the code read after the remaining bytes must match the model of the whole new sector. A second pairing is a byte arriving while gen_done is already high. The bench confirms that the byte has no effect by reading the code back afterwards. The checker is swept over every data-bit and code-bit flip of a 24-byte configuration, and over out-of-range and two-bit differences.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  typedef enum logic [1:0] {
    HECC_CLEAN     = 2'd0,
    HECC_FIXED     = 2'd1,
    HECC_CODE_FLIP = 2'd2,
    HECC_FATAL     = 2'd3
  } hecc_result_e;

  localparam int BYTE_BITS = 8;
  localparam int BITPOS_W  = 3;

endpackage

// File: rtl/hecc_parity_gen.sv
module hecc_parity_gen #(
  parameter int SECTOR_BYTES = 512,
  parameter int BYTE_W       = $clog2(SECTOR_BYTES),
  parameter int HALF_W       = BYTE_W + hecc_pkg::BITPOS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic [HALF_W-1:0] par_hi,
  output logic [HALF_W-1:0] par_lo,
  output logic              full
);
  localparam int CNT_W = BYTE_W + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SECTOR_BYTES);
  localparam int BP_W = hecc_pkg::BITPOS_W;

  logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_inc;
  logic [HALF_W-1:0] hi_q, lo_q, hi_base, lo_base, hi_c, lo_c;
  logic [BP_W-1:0]   bp_hi, bp_lo;
  logic [BYTE_W-1:0] ix_hi, ix_lo;
  logic              full_q, take, byte_par;

  // a restart discards history in the same cycle
  always_comb begin
    cnt_base = restart ? '0 : cnt_q;
    hi_base  = restart ? '0 : hi_q;
    lo_base  = restart ? '0 : lo_q;
    take     = in_valid && (restart || !full_q);
    cnt_inc  = cnt_base + CNT_W'(1);
    byte_par = ^in_byte;
  end

  // bit-position parities within one byte
  always_comb begin
    bp_hi = '0;
    bp_lo = '0;
    for (int b = 0; b < hecc_pkg::BYTE_BITS; b++) begin
      for (int k = 0; k < BP_W; k++) begin
        if (((b >> k) & 1) == 1) bp_hi[k] = bp_hi[k] ^ in_byte[b];
        else                     bp_lo[k] = bp_lo[k] ^ in_byte[b];
      end
    end
  end

  // byte-index parities: whole-byte parity steered by index bit
  for (genvar j = 0; j < BYTE_W; j++) begin : g_idx
    assign ix_hi[j] = cnt_base[j] & byte_par;
    assign ix_lo[j] = ~cnt_base[j] & byte_par;
  end

  assign hi_c = {ix_hi, bp_hi};
  assign lo_c = {ix_lo, bp_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      full_q <= 1'b0;
    end else if (take) begin
      cnt_q  <= cnt_inc;
      hi_q   <= hi_base ^ hi_c;
      lo_q   <= lo_base ^ lo_c;
      full_q <= (cnt_inc == LAST_CNT);
    end else if (restart) begin
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      full_q <= 1'b0;
    end
  end

  assign par_hi = hi_q;
  assign par_lo = lo_q;
  assign full   = full_q;

endmodule

// File: rtl/hecc_code_pack.sv
module hecc_code_pack #(
  parameter int HALF_W = 12,
  parameter int CODE_W = 2 * HALF_W
) (
  input  logic [HALF_W-1:0] par_hi,
  input  logic [HALF_W-1:0] par_lo,
  output logic [CODE_W-1:0] code
);
  // inversion makes an erased (all-ones) sector carry an all-ones code
  assign code = ~{par_hi, par_lo};
endmodule

// File: rtl/hecc_syndrome_chk.sv
module hecc_syndrome_chk #(
  parameter int SECTOR_BYTES = 512,
  parameter int BYTE_W       = $clog2(SECTOR_BYTES),
  parameter int HALF_W       = BYTE_W + hecc_pkg::BITPOS_W,
  parameter int CODE_W       = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] stored,
  input  logic [CODE_W-1:0] calc,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [BYTE_W-1:0] out_byte,
  output logic [2:0]        out_bit
);
  import hecc_pkg::*;

  localparam logic [BYTE_W:0] LIMIT = (BYTE_W + 1)'(SECTOR_BYTES);

  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] d_hi, d_lo;
  logic [BYTE_W-1:0] loc_byte;
  logic [2:0]        loc_bit;
  logic              is_zero, is_compl, is_single, in_range;
  hecc_result_e      kind_c;

  always_comb begin
    diff      = stored ^ calc;
    d_hi      = diff[CODE_W-1:HALF_W];
    d_lo      = diff[HALF_W-1:0];
    loc_bit   = d_hi[2:0];
    loc_byte  = d_hi[HALF_W-1:3];
    is_zero   = (diff == '0);
    is_compl  = ((d_hi ^ d_lo) == '1);
    is_single = $onehot(diff);
    in_range  = ({1'b0, loc_byte} < LIMIT);
    if (is_zero)                   kind_c = HECC_CLEAN;
    else if (is_compl && in_range) kind_c = HECC_FIXED;
    else if (is_compl)             kind_c = HECC_FATAL;
    else if (is_single)            kind_c = HECC_CODE_FLIP;
    else                           kind_c = HECC_FATAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= HECC_CLEAN;
      out_byte  <= '0;
      out_bit   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_kind <= kind_c;
        out_byte <= (kind_c == HECC_FIXED) ? loc_byte : '0;
        out_bit  <= (kind_c == HECC_FIXED) ? loc_bit  : '0;
      end
    end
  end

endmodule

// File: rtl/nand_hecc_engine.sv
module nand_hecc_engine #(
  parameter int SECTOR_BYTES = 512,
  parameter int BYTE_W       = $clog2(SECTOR_BYTES),
  parameter int HALF_W       = BYTE_W + hecc_pkg::BITPOS_W,
  parameter int CODE_W       = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              code_rd,
  output logic              gen_done,
  output logic              code_valid,
  output logic [CODE_W-1:0] code_out,
  input  logic              chk_valid,
  input  logic [CODE_W-1:0] chk_stored,
  input  logic [CODE_W-1:0] chk_calc,
  output logic              res_valid,
  output logic [1:0]        res_kind,
  output logic [BYTE_W-1:0] err_byte,
  output logic [2:0]        err_bit
);
  logic [HALF_W-1:0] par_hi, par_lo;
  logic [CODE_W-1:0] packed_code, code_q;
  logic              code_valid_q;

  hecc_parity_gen #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .BYTE_W      (BYTE_W),
    .HALF_W      (HALF_W)
  ) u_gen (
    .clk     (clk),
    .rst     (rst),
    .restart (code_rd),
    .in_valid(byte_valid),
    .in_byte (byte_data),
    .par_hi  (par_hi),
    .par_lo  (par_lo),
    .full    (gen_done)
  );

  hecc_code_pack #(
    .HALF_W(HALF_W),
    .CODE_W(CODE_W)
  ) u_pack (
    .par_hi(par_hi),
    .par_lo(par_lo),
    .code  (packed_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q       <= '0;
      code_valid_q <= 1'b0;
    end else begin
      code_valid_q <= code_rd;
      if (code_rd) code_q <= packed_code;
    end
  end

  assign code_out   = code_q;
  assign code_valid = code_valid_q;

  hecc_syndrome_chk #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .BYTE_W      (BYTE_W),
    .HALF_W      (HALF_W),
    .CODE_W      (CODE_W)
  ) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (chk_valid),
    .stored   (chk_stored),
    .calc     (chk_calc),
    .out_valid(res_valid),
    .out_kind (res_kind),
    .out_byte (err_byte),
    .out_bit  (err_bit)
  );

endmodule

// File: rtl/nand_hecc_engine_sva.sv
module nand_hecc_engine_sva #(
  parameter int SECTOR_BYTES = 512,
  parameter int BYTE_W       = $clog2(SECTOR_BYTES),
  parameter int HALF_W       = BYTE_W + 3,
  parameter int CODE_W       = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              code_rd,
  input logic              gen_done,
  input logic              code_valid,
  input logic              chk_valid,
  input logic [CODE_W-1:0] chk_stored,
  input logic [CODE_W-1:0] chk_calc,
  input logic              res_valid,
  input logic [1:0]        res_kind,
  input logic [BYTE_W-1:0] err_byte
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!gen_done && !code_valid && !res_valid));

  a_r4_done_sticks: assert property (@(posedge clk) disable iff (rst)
    (gen_done && !code_rd) |=> gen_done);

  a_r5_read_clears_done: assert property (@(posedge clk) disable iff (rst)
    code_rd |=> (code_valid && !gen_done));

  a_r5_no_spurious_code: assert property (@(posedge clk) disable iff (rst)
    !code_rd |=> !code_valid);

  a_r11_result_follows: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> res_valid);

  a_r11_no_spurious_result: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !res_valid);

  a_r6_match_is_clean: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_stored == chk_calc) |=> (res_kind == 2'd0));

  a_r9_single_code_bit: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && $onehot(chk_stored ^ chk_calc)) |=> (res_kind == 2'd2));

  a_r8_fix_in_range: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_kind == 2'd1) |-> ({1'b0, err_byte} < (BYTE_W + 1)'(SECTOR_BYTES)));
endmodule

bind nand_hecc_engine nand_hecc_engine_sva #(
  .SECTOR_BYTES(SECTOR_BYTES),
  .BYTE_W      (BYTE_W),
  .HALF_W      (HALF_W),
  .CODE_W      (CODE_W)
) u_sva (
  .clk       (clk),
  .rst       (rst),
  .code_rd   (code_rd),
  .gen_done  (gen_done),
  .code_valid(code_valid),
  .chk_valid (chk_valid),
  .chk_stored(chk_stored),
  .chk_calc  (chk_calc),
  .res_valid (res_valid),
  .res_kind  (res_kind),
  .err_byte  (err_byte)
);

// File: tb/nand_hecc_engine_tb.sv
module nand_hecc_engine_tb;
  localparam int SB = 24;
  localparam int BW = 5;
  localparam int HW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          byte_valid = 1'b0;
  logic [7:0]    byte_data = '0;
  logic          code_rd = 1'b0;
  logic          gen_done, code_valid;
  logic [CW-1:0] code_out;
  logic          chk_valid = 1'b0;
  logic [CW-1:0] chk_stored = '0, chk_calc = '0;
  logic          res_valid;
  logic [1:0]    res_kind;
  logic [BW-1:0] err_byte;
  logic [2:0]    err_bit;

  int checks = 0;
  int fails  = 0;
  logic [7:0] sec [SB];

  always #4 clk = ~clk;

  nand_hecc_engine #(.SECTOR_BYTES(SB)) u_dut (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .code_rd(code_rd), .gen_done(gen_done), .code_valid(code_valid),
    .code_out(code_out), .chk_valid(chk_valid), .chk_stored(chk_stored),
    .chk_calc(chk_calc), .res_valid(res_valid), .res_kind(res_kind),
    .err_byte(err_byte), .err_bit(err_bit)
  );

  task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent model of the code; fb >= 0 flips one data bit
  function automatic logic [CW-1:0] model(int fb);
    logic [HW-1:0] hi, lo;
    hi = '0;
    lo = '0;
    for (int i = 0; i < SB; i++) begin
      for (int b = 0; b < 8; b++) begin
        int a;
        logic v;
        a = i * 8 + b;
        v = sec[i][b] ^ (a == fb);
        for (int k = 0; k < HW; k++) begin
          if (a[k]) hi[k] = hi[k] ^ v;
          else      lo[k] = lo[k] ^ v;
        end
      end
    end
    return ~{hi, lo};
  endfunction

  task automatic push(logic [7:0] d);
    byte_valid = 1'b1;
    byte_data  = d;
    @(negedge clk);
  endtask

  task automatic stream_all();
    for (int i = 0; i < SB; i++) push(sec[i]);
    byte_valid = 1'b0;
  endtask

  task automatic read_code(output logic [CW-1:0] c);
    code_rd = 1'b1;
    @(negedge clk);
    code_rd = 1'b0;
    expect_eq("R5 code_valid after read", code_valid, 1);
    expect_eq("R5 done cleared by read", gen_done, 0);
    c = code_out;
  endtask

  task automatic do_chk(string tag, logic [CW-1:0] s, logic [CW-1:0] c,
                        logic [1:0] ek, int eb, int ebit);
    chk_valid  = 1'b1;
    chk_stored = s;
    chk_calc   = c;
    @(negedge clk);
    chk_valid = 1'b0;
    expect_eq({tag, " R11 res_valid"}, res_valid, 1);
    expect_eq({tag, " kind"}, res_kind, ek);
    if (ek == 2'd1) begin
      expect_eq({tag, " byte"}, err_byte, eb);
      expect_eq({tag, " bit"}, err_bit, ebit);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [CW-1:0] c, ca, good;
    repeat (3) @(negedge clk);
    expect_eq("R1 gen_done in reset", gen_done, 0);
    expect_eq("R1 code_valid in reset", code_valid, 0);
    expect_eq("R1 res_valid in reset", res_valid, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2: several data patterns
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < SB; i++)
        sec[i] = (p == 0) ? 8'(i * 37 + 5) : (p == 1) ? 8'(1 << (i % 8)) : 8'(i ^ 8'h5A);
      stream_all();
      expect_eq("R4 done after last byte", gen_done, 1);
      read_code(c);
      expect_eq("R2 code pattern", c, model(-1));
    end

    // R3: erased sector
    for (int i = 0; i < SB; i++) sec[i] = 8'hFF;
    stream_all();
    read_code(c);
    expect_eq("R3 erased code all ones", c, {CW{1'b1}});

    // R4: bytes after done are ignored
    for (int i = 0; i < SB; i++) sec[i] = 8'(i * 11 + 3);
    for (int i = 0; i < SB - 1; i++) push(sec[i]);
    byte_valid = 1'b0;
    expect_eq("R4 not done one byte short", gen_done, 0);
    push(sec[SB-1]);
    push(8'hA5);
    push(8'h3C);
    byte_valid = 1'b0;
    expect_eq("R4 done held", gen_done, 1);
    read_code(c);
    expect_eq("R4 extra bytes ignored", c, model(-1));

    // R5: read in the same cycle as the first byte of the next sector
    stream_all();
    ca = model(-1);
    for (int i = 0; i < SB; i++) sec[i] = 8'(i * 29 + 71);
    code_rd    = 1'b1;
    byte_valid = 1'b1;
    byte_data  = sec[0];
    @(negedge clk);
    code_rd = 1'b0;
    expect_eq("R5 collide code_valid", code_valid, 1);
    expect_eq("R5 collide old code", code_out, ca);
    for (int i = 1; i < SB; i++) push(sec[i]);
    byte_valid = 1'b0;
    expect_eq("R5 collide done", gen_done, 1);
    read_code(c);
    expect_eq("R5 collide new sector code", c, model(-1));
    @(negedge clk);
    expect_eq("R5 code_valid single cycle", code_valid, 0);

    // R6: clean match
    good = model(-1);
    do_chk("R6 clean", good, good, 2'd0, 0, 0);

    // R7: every single data-bit flip
    for (int p = 0; p < SB * 8; p++)
      do_chk("R7 data flip", good, model(p), 2'd1, p / 8, p % 8);

    // R7 end to end through the generator
    sec[9][5] = ~sec[9][5];
    stream_all();
    read_code(c);
    sec[9][5] = ~sec[9][5];
    do_chk("R7 end to end", good, c, 2'd1, 9, 5);

    // R9: every single code-bit flip
    for (int q = 0; q < CW; q++)
      do_chk("R9 code flip", good, good ^ CW'(1 << q), 2'd2, 0, 0);

    // R8: complement pattern naming a byte beyond the sector
    for (int b = SB; b < (1 << BW); b++) begin
      for (int t = 0; t < 8; t++) begin
        logic [HW-1:0] a;
        a = HW'(b * 8 + t);
        do_chk("R8 out of range", good, good ^ {a, ~a}, 2'd3, 0, 0);
      end
    end

    // R10: two data-bit flips and arbitrary multi-bit differences
    for (int p = 0; p < SB * 8 - 1; p += 7) begin
      logic [CW-1:0] d;
      d = model(p) ^ model(p + 1) ^ good;
      do_chk("R10 double flip", good, d, 2'd3, 0, 0);
    end
    do_chk("R10 two code bits", good, good ^ 16'h0101, 2'd3, 0, 0);

    @(negedge clk);
    expect_eq("R11 res_valid drops", res_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule